// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a chipset-style watchdog with a small register file on a 32-bit word bus. Software programs a timer value in ticks and writes the reload field. The down-counter then starts from that value and steps once per tick. A tick is a fixed number of tenths of a second, set by parameters. The default is six tenths, so N seconds is N*10/6 ticks. When the count runs out it reloads from the timer value on its own and keeps counting.

The first expiry after a reload only sets a timeout status flag. The next expiry is the second stage. It sets a second-timeout flag. If the no-reboot input is low, it also fires a one-cycle action pulse, tagged with the action code on the select input, and it sets a boot status flag. The status flags are sticky and clear when software writes a 1 to them. Writes to two software data bytes raise status flags of their own. A halt bit freezes the countdown, and a lock bit cannot be cleared once it has been set.

Top module: `wdog_twostage`

## Requirements
- R1: Register words are addressed by `bus_idx`. Word 0 holds the count in [15:0], data-in in [23:16] and data-out in [31:24]. Word 1 holds status 1 in [15:0] and status 2 in [31:16]. Word 2 holds control 1 in [15:0] and control 2 in [31:16]. Word 3 holds, from the low byte up, message 1, message 2, watchdog count and IRQ-generate. Word 4 holds the timer value in [15:0]. After reset, word 0, word 1 and control 1 read zero, control 2 reads 0x0008, the timer value reads 0x0004, IRQ-generate reads 0x03 and the other bytes read zero. Byte strobes select the bytes that a write changes.
- R2: A write to word 0 with strobe bit 0 or 1 set copies the timer value into the counter. Word 0 [15:0] then reads the live count, which drops by one every tick (CLK_HZ/10*TICK_TENTHS cycles).
- R3: Control 1 bit 11 (halt) freezes the count while set, and counting resumes once it is cleared.
- R4: When the count reads 1, no timeout is flagged yet. The next tick is an expiry: it sets status 1 bit 3 (timeout), and the counter reloads from the timer value and keeps counting.
- R5: The first expiry after a reload sets only status 1 bit 3. Writing 1 to that bit clears it.
- R6: The expiry that follows a first expiry sets status 2 bit 1 (second timeout) and status 1 bit 3 again. The expiry after a second-stage expiry counts as a first expiry again.
- R7: With `no_reboot` low, a second-stage expiry gives a `act_pulse` exactly one cycle wide, with `act_code` equal to `act_sel` (0 none, 1 reset, 2 pause, 3 shutdown), and sets status 2 bit 2 (boot). A first-stage expiry raises no pulse.
- R8: With `no_reboot` high, a second-stage expiry raises no pulse and leaves status 2 bit 2 clear.
- R9: Control 1 bit 12 (lock), once written 1, stays 1 when later writes carry 0. Only reset clears it.
- R10: A write to the data-in byte sets status 1 bit 8. A write to the data-out byte sets status 1 bit 9. Both bytes keep the value written.
- R11: Writing back the read value of word 1 clears every set status bit, including second timeout and boot.
- R12: The timer value is kept only to TMR_W bits (default 10), so writing 0xFFFF reads back and loads as 0x03FF.
- R13: A loaded value of zero expires on the next tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_idx | input | ADDR_W | Register word index |
| bus_wstrb | input | 4 | Byte enables for a write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the indexed word (combinational) |
| no_reboot | input | 1 | When high, the second stage fires no action |
| act_sel | input | 2 | Action code to report with the pulse |
| act_pulse | output | 1 | One-cycle second-stage action pulse |
| act_code | output | 2 | Action code captured at the last pulse |

## Verification
The bench pins the expiry edge from both sides. It reads the count at 1 and sees no flag, then sees the flag one tick later. A design that expires at zero would be a tick late, and one that expires at two would be early. It tells the first stage from the second by checking that no pulse and no second-timeout bit appear at the first expiry. A stage flag that is never cleared, or is cleared by the status write, would fire too early or too late. Further checks cover a zero timer value, the 10-bit masking of 0xFFFF and a lock write of 0. A design that loads unmasked values, waits a full wrap at zero, or lets the lock be cleared would each fail one of those checks.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
   // register word indices
   localparam int W_CNTDATA = 0;
   localparam int W_STATUS  = 1;
   localparam int W_CTRL    = 2;
   localparam int W_MISC    = 3;
   localparam int W_TIMER   = 4;

   // bit positions
   localparam int S1_TMO    = 3;
   localparam int S1_DIN    = 8;
   localparam int S1_DOUT   = 9;
   localparam int S2_SECOND = 1;
   localparam int S2_BOOT   = 2;
   localparam int C1_HALT   = 11;
   localparam int C1_LOCK   = 12;

   // reset values
   localparam logic [15:0] CTRL2_RST = 16'h0008;
   localparam logic [15:0] TIMER_RST = 16'h0004;
   localparam logic [7:0]  IRQG_RST  = 8'h03;

   typedef enum logic [1:0] {
      ACT_NONE     = 2'd0,
      ACT_RESET    = 2'd1,
      ACT_PAUSE    = 2'd2,
      ACT_SHUTDOWN = 2'd3
   } act_e;

   function automatic logic [15:0] merge16(input logic [15:0] old_v,
                                           input logic [15:0] new_v,
                                           input logic [1:0]  be);
      logic [15:0] m;
      m = {{8{be[1]}}, {8{be[0]}}};
      return (old_v & ~m) | (new_v & m);
   endfunction

   function automatic logic [15:0] w1c16(input logic [15:0] old_v,
                                         input logic [15:0] wr_v,
                                         input logic [1:0]  be);
      return old_v & ~(wr_v & {{8{be[1]}}, {8{be[0]}}});
   endfunction
endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
   parameter int unsigned TICK_CYCLES = 150_000_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic restart,
   output logic tick
);
   localparam int unsigned PW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
   localparam logic [PW-1:0] LAST = PW'(TICK_CYCLES - 1);

   if (TICK_CYCLES < 2) begin : g_bad_tick
      $error("wdog_prescaler: TICK_CYCLES must be at least 2");
   end

   logic [PW-1:0] div_q;

   always_ff @(posedge clk) begin
      if (!rst_n || restart) begin
         div_q <= '0;
      end else if (run) begin
         if (div_q == LAST) div_q <= '0;
         else               div_q <= div_q + PW'(1);
      end
   end

   assign tick = run && !restart && (div_q == LAST);
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
   parameter int TMR_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             reload,
   input  logic [TMR_W-1:0] load_val,
   output logic [TMR_W-1:0] count,
   output logic             expire
);
   logic [TMR_W-1:0] cnt_q;
   logic             exp_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         exp_q <= 1'b0;
      end else begin
         exp_q <= 1'b0;
         if (reload) begin
            cnt_q <= load_val;
         end else if (tick) begin
            if (cnt_q <= TMR_W'(1)) begin
               cnt_q <= load_val;   // wrap and keep running
               exp_q <= 1'b1;
            end else begin
               cnt_q <= cnt_q - TMR_W'(1);
            end
         end
      end
   end

   assign count  = cnt_q;
   assign expire = exp_q;
endmodule

// File: rtl/wdog_stage.sv
module wdog_stage (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       expire,
   input  logic       rearm,
   input  logic       no_reboot,
   input  logic [1:0] act_sel,
   output logic       second_hit,
   output logic       boot_hit,
   output logic       act_pulse,
   output logic [1:0] act_code
);
   logic       armed_q;
   logic       pulse_q;
   logic [1:0] code_q;

   assign second_hit = expire && armed_q;
   assign boot_hit   = second_hit && !no_reboot;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         pulse_q <= 1'b0;
         code_q  <= 2'd0;
      end else begin
         pulse_q <= boot_hit;
         if (boot_hit) code_q <= act_sel;
         if (rearm)       armed_q <= 1'b0;
         else if (expire) armed_q <= !armed_q;
      end
   end

   assign act_pulse = pulse_q;
   assign act_code  = code_q;
endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
   import wdog_pkg::*;
#(
   parameter int ADDR_W = 3,
   parameter int TMR_W  = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_idx,
   input  logic [3:0]        bus_wstrb,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic [TMR_W-1:0]  count,
   input  logic              expire,
   input  logic              second_hit,
   input  logic              boot_hit,
   output logic              reload,
   output logic              halt,
   output logic              lock,
   output logic              sts2_second,
   output logic [TMR_W-1:0]  timer_val
);
   logic [7:0]       din_q, dout_q, msg1_q, msg2_q, wdc_q, irqg_q;
   logic [15:0]      sts1_q, sts2_q, ctrl2_q;
   logic             halt_q, lock_q;
   logic [TMR_W-1:0] tmr_q;
   logic [15:0]      cnt_rd, tmr_rd, ctrl1_rd;
   logic [15:0]      sts1_n, sts2_n;

   logic wr_cd, wr_st, wr_ct, wr_mi, wr_tm;
   assign wr_cd = bus_wr && (bus_idx == ADDR_W'(W_CNTDATA));
   assign wr_st = bus_wr && (bus_idx == ADDR_W'(W_STATUS));
   assign wr_ct = bus_wr && (bus_idx == ADDR_W'(W_CTRL));
   assign wr_mi = bus_wr && (bus_idx == ADDR_W'(W_MISC));
   assign wr_tm = bus_wr && (bus_idx == ADDR_W'(W_TIMER));

   assign reload = wr_cd && (bus_wstrb[0] || bus_wstrb[1]);

   // zero-pad the narrow fields to the 16-bit register view
   if (TMR_W < 16) begin : g_pad
      assign cnt_rd = {{(16-TMR_W){1'b0}}, count};
      assign tmr_rd = {{(16-TMR_W){1'b0}}, tmr_q};
   end else begin : g_full
      assign cnt_rd = count;
      assign tmr_rd = tmr_q;
   end

   always_comb begin
      ctrl1_rd          = '0;
      ctrl1_rd[C1_HALT] = halt_q;
      ctrl1_rd[C1_LOCK] = lock_q;
   end

   // plain storage and control
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         din_q   <= '0;
         dout_q  <= '0;
         msg1_q  <= '0;
         msg2_q  <= '0;
         wdc_q   <= '0;
         irqg_q  <= IRQG_RST;
         ctrl2_q <= CTRL2_RST;
         halt_q  <= 1'b0;
         lock_q  <= 1'b0;
         tmr_q   <= TMR_W'(TIMER_RST);
      end else begin
         if (wr_cd && bus_wstrb[2]) din_q  <= bus_wdata[23:16];
         if (wr_cd && bus_wstrb[3]) dout_q <= bus_wdata[31:24];
         if (wr_ct) begin
            if (bus_wstrb[1]) begin
               halt_q <= bus_wdata[C1_HALT];
               lock_q <= lock_q | bus_wdata[C1_LOCK];
            end
            ctrl2_q <= merge16(ctrl2_q, bus_wdata[31:16], bus_wstrb[3:2]);
         end
         if (wr_mi) begin
            if (bus_wstrb[0]) msg1_q <= bus_wdata[7:0];
            if (bus_wstrb[1]) msg2_q <= bus_wdata[15:8];
            if (bus_wstrb[2]) wdc_q  <= bus_wdata[23:16];
            if (bus_wstrb[3]) irqg_q <= bus_wdata[31:24];
         end
         if (wr_tm)
            tmr_q <= TMR_W'(merge16(tmr_rd, bus_wdata[15:0], bus_wstrb[1:0]));
      end
   end

   // sticky status: hardware set wins over a same-cycle clear
   always_comb begin
      sts1_n = wr_st ? w1c16(sts1_q, bus_wdata[15:0], bus_wstrb[1:0]) : sts1_q;
      sts2_n = wr_st ? w1c16(sts2_q, bus_wdata[31:16], bus_wstrb[3:2]) : sts2_q;
      if (expire)                    sts1_n[S1_TMO]    = 1'b1;
      if (wr_cd && bus_wstrb[2])     sts1_n[S1_DIN]    = 1'b1;
      if (wr_cd && bus_wstrb[3])     sts1_n[S1_DOUT]   = 1'b1;
      if (second_hit)                sts2_n[S2_SECOND] = 1'b1;
      if (boot_hit)                  sts2_n[S2_BOOT]   = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sts1_q <= '0;
         sts2_q <= '0;
      end else begin
         sts1_q <= sts1_n;
         sts2_q <= sts2_n;
      end
   end

   always_comb begin
      case (bus_idx)
         ADDR_W'(W_CNTDATA): bus_rdata = {dout_q, din_q, cnt_rd};
         ADDR_W'(W_STATUS):  bus_rdata = {sts2_q, sts1_q};
         ADDR_W'(W_CTRL):    bus_rdata = {ctrl2_q, ctrl1_rd};
         ADDR_W'(W_MISC):    bus_rdata = {irqg_q, wdc_q, msg2_q, msg1_q};
         ADDR_W'(W_TIMER):   bus_rdata = {16'h0000, tmr_rd};
         default:            bus_rdata = '0;
      endcase
   end

   assign halt        = halt_q;
   assign lock        = lock_q;
   assign sts2_second = sts2_q[S2_SECOND];
   assign timer_val   = tmr_q;
endmodule

// File: rtl/wdog_twostage.sv
module wdog_twostage #(
   parameter int unsigned CLK_HZ      = 250_000_000,
   parameter int unsigned TICK_TENTHS = 6,
   parameter int          TMR_W       = 10,
   parameter int          ADDR_W      = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_idx,
   input  logic [3:0]        bus_wstrb,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic              no_reboot,
   input  logic [1:0]        act_sel,
   output logic              act_pulse,
   output logic [1:0]        act_code
);
   localparam int unsigned TICK_CYCLES = (CLK_HZ / 10) * TICK_TENTHS;

   if (TMR_W < 2 || TMR_W > 16) begin : g_bad_w
      $error("wdog_twostage: TMR_W must be 2..16");
   end
   if (ADDR_W < 3) begin : g_bad_a
      $error("wdog_twostage: ADDR_W must reach five words");
   end
   if (TICK_TENTHS < 1) begin : g_bad_t
      $error("wdog_twostage: TICK_TENTHS must be positive");
   end

   logic             tick_w, reload_w, halt_w, lock_w, expire_w;
   logic             second_w, boot_w, sts2_second;
   logic [TMR_W-1:0] count_w, tval_w;

   wdog_prescaler #(.TICK_CYCLES(TICK_CYCLES)) u_pre (
      .clk(clk), .rst_n(rst_n), .run(!halt_w), .restart(reload_w), .tick(tick_w)
   );

   wdog_counter #(.TMR_W(TMR_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .tick(tick_w), .reload(reload_w),
      .load_val(tval_w), .count(count_w), .expire(expire_w)
   );

   wdog_stage u_stage (
      .clk(clk), .rst_n(rst_n), .expire(expire_w), .rearm(reload_w),
      .no_reboot(no_reboot), .act_sel(act_sel), .second_hit(second_w),
      .boot_hit(boot_w), .act_pulse(act_pulse), .act_code(act_code)
   );

   wdog_regs #(.ADDR_W(ADDR_W), .TMR_W(TMR_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_idx(bus_idx),
      .bus_wstrb(bus_wstrb), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .count(count_w), .expire(expire_w), .second_hit(second_w),
      .boot_hit(boot_w), .reload(reload_w), .halt(halt_w), .lock(lock_w),
      .sts2_second(sts2_second), .timer_val(tval_w)
   );
endmodule

// File: rtl/wdog_twostage_chk.sv
module wdog_twostage_chk #(
   parameter int CW = 10
) (
   input logic          clk,
   input logic          rst_n,
   input logic          act_pulse,
   input logic          no_reboot,
   input logic          sts2_second,
   input logic          lock,
   input logic          tick,
   input logic          reload,
   input logic          halt,
   input logic [CW-1:0] count
);
   // R7: the action pulse lasts one cycle
   a_r7_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
      act_pulse |=> !act_pulse);

   // R7: a pulse always comes with the second-timeout flag
   a_r7_pulse_marks_status: assert property (@(posedge clk) disable iff (!rst_n)
      act_pulse |-> sts2_second);

   // R8: no pulse while the no-reboot input was high
   a_r8_inhibit: assert property (@(posedge clk) disable iff (!rst_n)
      act_pulse |-> !$past(no_reboot));

   // R9: lock never falls outside reset
   a_r9_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      lock |=> lock);

   // R2: count moves only on a tick or a reload
   a_r2_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !reload) |=> $stable(count));

   // R3: halted timer holds its count
   a_r3_halt_freeze: assert property (@(posedge clk) disable iff (!rst_n)
      (halt && !reload) |=> $stable(count));
endmodule

bind wdog_twostage wdog_twostage_chk #(.CW(TMR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .act_pulse(act_pulse), .no_reboot(no_reboot),
   .sts2_second(sts2_second), .lock(lock_w), .tick(tick_w),
   .reload(reload_w), .halt(halt_w), .count(count_w)
);

// File: tb/wdog_twostage_bench.sv
`timescale 1ns/1ps
module wdog_twostage_bench;
   localparam int ADDR_W = 3;
   localparam int TC     = 30;             // cycles per tick at CLK_HZ=50
   localparam logic [31:0] HALT = 32'h0000_0800;
   localparam logic [31:0] LOCK = 32'h0000_1000;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              bus_wr = 1'b0;
   logic [ADDR_W-1:0] bus_idx = '0;
   logic [3:0]        bus_wstrb = '0;
   logic [31:0]       bus_wdata = '0;
   logic [31:0]       bus_rdata;
   logic              no_reboot = 1'b1;
   logic [1:0]        act_sel = 2'd0;
   logic              act_pulse;
   logic [1:0]        act_code;

   always #2 clk = ~clk;   // 250 MHz

   wdog_twostage #(.CLK_HZ(50), .TICK_TENTHS(6), .TMR_W(10), .ADDR_W(ADDR_W))
   u_wdog_twostage (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_idx(bus_idx),
      .bus_wstrb(bus_wstrb), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .no_reboot(no_reboot), .act_sel(act_sel), .act_pulse(act_pulse),
      .act_code(act_code)
   );

   typedef struct {
      logic [31:0] exp;
      logic [31:0] mask;
      string       tag;
   } item_t;

   item_t exp_q[$];
   event  mon_ev;
   int    checks = 0;
   int    errors = 0;
   int    pulses = 0;
   bit    done = 0;

   always @(posedge clk) if (rst_n && act_pulse) pulses <= pulses + 1;

   // monitor: pops expected reads and compares them
   initial begin
      item_t it;
      forever begin
         @(mon_ev);
         it = exp_q.pop_front();
         checks++;
         if ((bus_rdata & it.mask) !== (it.exp & it.mask)) begin
            errors++;
            $display("FAIL %s: actual %08h expected %08h", it.tag,
                     bus_rdata & it.mask, it.exp & it.mask);
         end
      end
   end

   task automatic wr(input int w, input logic [31:0] d, input logic [3:0] be);
      bus_idx   = ADDR_W'(w);
      bus_wdata = d;
      bus_wstrb = be;
      bus_wr    = 1'b1;
      @(negedge clk);
      bus_wr    = 1'b0;
      bus_wstrb = '0;
   endtask

   task automatic rd(input int w, input logic [31:0] e, input logic [31:0] m,
                     input string tag);
      item_t it;
      bus_idx = ADDR_W'(w);
      it.exp = e; it.mask = m; it.tag = tag;
      exp_q.push_back(it);
      #0.2;
      -> mon_ev;
      #0.2;
   endtask

   task automatic chk(input logic [31:0] a, input logic [31:0] e, input string tag);
      checks++;
      if (a !== e) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, a, e);
      end
   endtask

   task automatic waitc(input int n);
      repeat (n) @(negedge clk);
   endtask

   // halt, load value, reload, clear status; leaves timer halted
   task automatic arm(input logic [31:0] v);
      wr(2, HALT, 4'b0011);
      wr(4, v, 4'b0011);
      wr(0, 32'h0, 4'b0001);
      wr(1, 32'hFFFF_FFFF, 4'b1111);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      waitc(5);
      rst_n = 1'b1;
      // R1 reset values
      rd(0, 32'h0, 32'hFFFF_FFFF, "R1 word0 reset");
      rd(1, 32'h0, 32'hFFFF_FFFF, "R1 status reset");
      rd(2, 32'h0008_0000, 32'hFFFF_FFFF, "R1 control reset");
      rd(3, 32'h0300_0000, 32'hFFFF_FFFF, "R1 misc reset");
      rd(4, 32'h0000_0004, 32'hFFFF_FFFF, "R1 timer reset");

      // R9 lock sticky
      wr(2, LOCK, 4'b0011);
      wr(2, 32'h0, 4'b0011);
      rd(2, LOCK, LOCK, "R9 lock stays set");

      // R2/R3/R4/R5 count sequence
      arm(6);
      rd(0, 6, 32'hFFFF, "R2 load copies timer value");
      waitc(100);
      rd(0, 6, 32'hFFFF, "R3 halted count frozen");
      wr(2, 32'h0, 4'b0011);
      waitc(14);
      rd(0, 6, 32'hFFFF, "R3 resume before first tick");
      for (int n = 1; n <= 5; n++) begin
         waitc(TC);
         rd(0, 6 - n, 32'hFFFF, "R2 count per tick");
      end
      rd(1, 0, 32'h8, "R4 count one no timeout");
      waitc(TC);
      rd(0, 6, 32'hFFFF, "R4 auto reload after expiry");
      rd(1, 32'h0000_0008, 32'h0006_0008, "R5 first expiry flags only timeout");
      chk(pulses, 0, "R7 no pulse on first expiry");
      wr(1, 32'h8, 4'b0001);
      rd(1, 0, 32'h8, "R5 timeout write-1-clear");
      waitc(180);
      rd(1, 32'h0002_0008, 32'h0006_0008, "R6 second expiry with no_reboot high");
      chk(pulses, 0, "R8 no pulse when inhibited");
      wr(1, 32'h0002_0008, 4'b1111);
      rd(1, 0, 32'hFFFF_FFFF, "R11 write-back clears status");

      // R7 action path
      no_reboot = 1'b0;
      act_sel   = 2'd2;
      arm(4);
      wr(2, 32'h0, 4'b0011);
      waitc(134);
      chk(pulses, 0, "R7 first stage silent");
      rd(1, 32'h8, 32'h0006_0008, "R6 first stage only timeout");
      waitc(120);
      chk(pulses, 1, "R7 one pulse cycle");
      chk(act_code, 2, "R7 action code");
      rd(1, 32'h0006_0008, 32'h0006_0008, "R7 boot and second set");
      no_reboot = 1'b1;
      wr(1, 32'h0006_0008, 4'b1111);
      rd(1, 0, 32'hFFFF_FFFF, "R11 clears boot and second");

      // R10 data bytes
      wr(2, HALT, 4'b0011);
      wr(1, 32'hFFFF_FFFF, 4'b1111);
      wr(0, 32'h00A5_0000, 4'b0100);
      rd(1, 32'h0100, 32'h0300, "R10 data-in flag");
      wr(0, 32'h5A00_0000, 4'b1000);
      rd(1, 32'h0300, 32'h0300, "R10 data-out flag");
      rd(0, 32'h5AA5_0000, 32'hFFFF_0000, "R10 data bytes kept");
      wr(3, 32'h1122_3344, 4'b1111);
      rd(3, 32'h1122_3344, 32'hFFFF_FFFF, "R1 misc bytes writable");
      wr(2, 32'hBEEF_0000, 4'b1100);
      rd(2, 32'hBEEF_0800, 32'hFFFF_0800, "R1 control 2 byte write");

      // R13 zero value
      arm(0);
      rd(0, 0, 32'hFFFF, "R13 zero loaded");
      wr(2, 32'h0, 4'b0011);
      waitc(14);
      rd(1, 0, 32'h8, "R13 no flag before tick");
      waitc(TC);
      rd(1, 32'h8, 32'h8, "R13 expiry on first tick");

      // R12 masking and R4 at maximum
      arm(32'hFFFF);
      rd(4, 32'h03FF, 32'hFFFF_FFFF, "R12 timer masked");
      rd(0, 32'h03FF, 32'hFFFF, "R12 masked load");
      wr(2, 32'h0, 4'b0011);
      waitc(1022 * TC + 14);
      rd(0, 1, 32'hFFFF, "R4 max count reaches one");
      rd(1, 0, 32'h8, "R4 max no timeout yet");
      waitc(TC);
      rd(1, 32'h8, 32'h8, "R4 max timeout after last tick");

      waitc(2);
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule